// File: doc/BRIEF.md
# Clear-on-Read Bus Read-Latency and Word-Transfer Counter

This block watches the read traffic of a bus master. It keeps two running statistics and packs them into one 32-bit read-only status word. The upper half holds the number of bus clocks spent with a read outstanding, summed over every read. The low byte holds the number of 32-bit data words the master has moved. The byte between them is always zero.

Host software reads the status word through a one-cycle read strobe. That read returns the totals gathered since the previous read and starts both tallies again from zero, so each read covers one measurement interval. Three single-cycle strobes from the bus engine drive the block: a request strobe when a read is issued, a done strobe when the access completes, and a transfer strobe for each data word. Both counts stop at their all-ones value instead of wrapping. A count event that lands in the same cycle as the clearing read is kept and carried into the next interval.

Top module: `bus_perf_counter`

## Requirements
- R1: Bits 31:16 of `csr_data_o` count bus clocks with a read outstanding. A read whose done strobe comes k cycles after its request strobe adds k+1: the request cycle through the done cycle, both included.
- R2: The clock count adds up the contributions of every read issued since the last host read of the word.
- R3: Bits 7:0 of `csr_data_o` increase by one in each cycle where `xfer_i` is high.
- R4: No clock is counted while no read is outstanding. A done strobe with no read outstanding has no effect. A second request during an outstanding read neither restarts nor double-counts the clock count.
- R5: Bits 15:8 of `csr_data_o` always read as zero.
- R6: After reset both counts read zero. A host read (`csr_rd_i` high for one cycle) returns the current counts, and both counts are zero after that cycle.
- R7: Each count stops at its all-ones value (16'hFFFF and 8'hFF) instead of wrapping.
- R8: When a count event falls in the cycle of a host read, the read returns the value from before that event. The count then restarts at that cycle's contribution of 1, so the event is not lost.
- R9: A request strobe and a done strobe in the same cycle, with no read outstanding, count exactly one clock and leave no read outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Strobe: the master issues a read request |
| rd_done_i | input | 1 | Strobe: the outstanding read access completes |
| xfer_i | input | 1 | Strobe: one 32-bit data word is transferred |
| csr_rd_i | input | 1 | Host read of the status word (clear on read) |
| csr_data_o | output | 32 | Status word: {clock count, 8'h00, word count} |

## Verification
The bench sweeps read latencies from zero to twenty cycles and word bursts from zero to forty. Each expected total is computed arithmetically. An off-by-one in where the count window starts or ends shows up as a latency one too high or too low. A design that counts idle cycles, or that restarts on a second request, reports too much. The bench drives both counters past their limits; a wrapping design returns a small number instead of all ones. It places transfer and busy cycles exactly on the clearing read; a design that drops that cycle returns zero in the next interval instead of the carried-over count.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int unsigned LAT_W_DEF  = 16;
  localparam int unsigned RSV_W_DEF  = 8;
  localparam int unsigned WORD_W_DEF = 8;
endpackage

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = inc ? ONE_V : '0;
    end else if (inc && (cnt_q != MAX_V)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/perf_read_tracker.sv
module perf_read_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic done,
  output logic busy,
  output logic active
);
  logic busy_q;
  logic busy_d;

  always_comb begin
    busy_d = (busy_q | req) & ~done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  assign busy   = busy_q;
  assign active = busy_q | req;
endmodule

// File: rtl/bus_perf_counter.sv
module bus_perf_counter
  import perf_cnt_pkg::*;
#(
  parameter int unsigned LAT_W  = LAT_W_DEF,
  parameter int unsigned RSV_W  = RSV_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_req_i,
  input  logic                            rd_done_i,
  input  logic                            xfer_i,
  input  logic                            csr_rd_i,
  output logic [LAT_W+RSV_W+WORD_W-1:0]   csr_data_o
);
  localparam int unsigned DATA_W = LAT_W + RSV_W + WORD_W;
  localparam int unsigned LAT_LO = RSV_W + WORD_W;

  logic              rd_busy;
  logic              rd_active;
  logic [LAT_W-1:0]  lat_cnt;
  logic [WORD_W-1:0] word_cnt;

  perf_read_tracker u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (rd_req_i),
    .done   (rd_done_i),
    .busy   (rd_busy),
    .active (rd_active)
  );

  perf_sat_counter #(.W(LAT_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (csr_rd_i),
    .inc   (rd_active),
    .cnt   (lat_cnt)
  );

  perf_sat_counter #(.W(WORD_W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (csr_rd_i),
    .inc   (xfer_i),
    .cnt   (word_cnt)
  );

  always_comb begin
    csr_data_o                        = '0;
    csr_data_o[DATA_W-1:LAT_LO]       = lat_cnt;
    csr_data_o[WORD_W-1:0]            = word_cnt;
  end
endmodule

// File: rtl/perf_cnt_checker.sv
module perf_cnt_checker #(
  parameter int unsigned LAT_W  = 16,
  parameter int unsigned RSV_W  = 8,
  parameter int unsigned WORD_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_req_i,
  input logic                          rd_done_i,
  input logic                          xfer_i,
  input logic                          csr_rd_i,
  input logic                          busy,
  input logic [LAT_W+RSV_W+WORD_W-1:0] csr_data_o
);
  localparam int unsigned DATA_W = LAT_W + RSV_W + WORD_W;
  localparam int unsigned LAT_LO = RSV_W + WORD_W;

  logic [LAT_W-1:0]  lat;
  logic [WORD_W-1:0] wrd;
  logic [RSV_W-1:0]  rsv;
  assign lat = csr_data_o[DATA_W-1:LAT_LO];
  assign wrd = csr_data_o[WORD_W-1:0];
  assign rsv = csr_data_o[LAT_LO-1:WORD_W];

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv == '0);

  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_i |=> (lat <= LAT_W'(1)) && (wrd <= WORD_W'(1)));

  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd_i && xfer_i && wrd != {WORD_W{1'b1}}) |=> wrd == $past(wrd) + WORD_W'(1));

  // R7
  word_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd_i && wrd == {WORD_W{1'b1}}) |=> wrd == {WORD_W{1'b1}});

  // R7
  lat_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd_i && lat == {LAT_W{1'b1}}) |=> lat == {LAT_W{1'b1}});

  // R4
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd_i && !rd_req_i && !busy) |=> $stable(lat));

  // R1
  lat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd_i && busy && lat != {LAT_W{1'b1}}) |=> lat == $past(lat) + LAT_W'(1));

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && rd_done_i) |=> !busy);
endmodule

bind bus_perf_counter perf_cnt_checker #(
  .LAT_W  (LAT_W),
  .RSV_W  (RSV_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req_i   (rd_req_i),
  .rd_done_i  (rd_done_i),
  .xfer_i     (xfer_i),
  .csr_rd_i   (csr_rd_i),
  .busy       (rd_busy),
  .csr_data_o (csr_data_o)
);

// File: tb/bus_perf_counter_bench.sv
module bus_perf_counter_bench;
  logic        clk;
  logic        rst_n;
  logic        rd_req_i;
  logic        rd_done_i;
  logic        xfer_i;
  logic        csr_rd_i;
  logic [31:0] csr_data_o;

  int checks;
  int failures;
  int cyc;

  bus_perf_counter u_bus_perf_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req_i),
    .rd_done_i  (rd_done_i),
    .xfer_i     (xfer_i),
    .csr_rd_i   (csr_rd_i),
    .csr_data_o (csr_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= 150000);
    failures = failures + 1;
    $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample before next posedge, advance
  task automatic step(input logic r, input logic d, input logic x);
    rd_req_i  = r;
    rd_done_i = d;
    xfer_i    = x;
    csr_rd_i  = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic read_ev(input logic r, input logic d, input logic x,
                         input int el, input int ew, input string tag);
    rd_req_i  = r;
    rd_done_i = d;
    xfer_i    = x;
    csr_rd_i  = 1'b1;
    chk({tag, " lat"}, {16'h0, csr_data_o[31:16]}, 32'(el));
    chk({tag, " word"}, {24'h0, csr_data_o[7:0]}, 32'(ew));
    chk("R5 reserved", {24'h0, csr_data_o[15:8]}, 32'h0);
    @(negedge clk);
    csr_rd_i = 1'b0;
  endtask

  task automatic read_chk(input int el, input int ew, input string tag);
    read_ev(1'b0, 1'b0, 1'b0, el, ew, tag);
  endtask

  task automatic one_read(input int k);
    step(1'b1, (k == 0), 1'b0);
    for (int i = 1; i < k; i++) step(1'b0, 1'b0, 1'b0);
    if (k > 0) step(1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    int sum;
    checks = 0; failures = 0; cyc = 0;
    rst_n = 1'b0; rd_req_i = 0; rd_done_i = 0; xfer_i = 0; csr_rd_i = 0;
    repeat (3) @(negedge clk);
    chk("R6 reset value", csr_data_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after reset", csr_data_o, 32'h0);

    // R1 latency sweep; R9 for k=0
    for (int k = 0; k <= 20; k++) begin
      one_read(k);
      idle(3);
      read_chk(k + 1, 0, (k == 0) ? "R9 same-cycle" : "R1 latency");
    end

    // R2 accumulation over several reads
    sum = 0;
    for (int k = 1; k <= 5; k++) begin
      one_read(k);
      idle(2);
      sum += k + 1;
    end
    read_chk(sum, 0, "R2 accumulate");
    read_chk(0, 0, "R6 cleared");

    // R3 word sweep
    for (int n = 0; n <= 40; n++) begin
      for (int i = 0; i < n; i++) begin
        step(1'b0, 1'b0, 1'b1);
        if (i % 3 == 0) idle(1);
      end
      read_chk(0, n, "R3 words");
    end

    // R4: stray done, nested request
    step(1'b0, 1'b1, 1'b0);
    idle(4);
    read_chk(0, 0, "R4 stray done");
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    idle(5);
    read_chk(5, 0, "R4 nested request");

    // R8: events in the clearing cycle
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    read_ev(1'b0, 1'b0, 1'b1, 0, 3, "R8 word on read");
    read_chk(0, 1, "R8 word carried");
    step(1'b1, 1'b0, 1'b0);
    idle(3);
    read_ev(1'b0, 1'b0, 1'b0, 4, 0, "R8 busy on read");
    idle(2);
    step(1'b0, 1'b1, 1'b0);
    idle(2);
    read_chk(4, 0, "R8 busy carried");

    // R7 saturation
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b1);
    read_chk(0, 255, "R7 word saturate");
    step(1'b1, 1'b0, 1'b0);
    idle(70000);
    step(1'b0, 1'b1, 1'b0);
    read_chk(65535, 0, "R7 latency saturate");
    read_chk(0, 0, "R6 cleared after saturate");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule